// File: doc/BRIEF.md
# Frame-Slipping Receive Elastic Buffer

This block moves received line words from the recovered line clock into the system backplane clock through a ring store. The line side writes each word at a write pointer that advances on the line clock. The system side reads at a read pointer that advances on the system clock whenever a read is requested. The two clocks drift against each other, so the pointers slowly approach one another. When they come too close, the block does not let the ring overflow or run dry. Instead it moves the read pointer by half of the active ring in one step, so a whole block of data is either repeated or skipped at a controlled point. It records the direction of the slip in a sticky flag and also pulses an event alongside the affected word.

The write pointer reaches the system domain as a Gray value through a synchroniser chain, and every slip decision is made on the system clock. A mode input picks the active ring length: two frames of 32 octets, one frame, or a short quarter ring. A fourth mode routes the line word straight to the output. In that mode no slip ever takes place, and the enable for the downstream time-slot stage is dropped. While the system side is idle, the read pointer is held half a ring behind the synchronised write pointer. Reset and any mode change restore that position and clear both flags.

Top module: `slip_elastic_buffer`

## Requirements
- R1: Without a slip, each word read is the word written immediately after the previously read word.
- R2: A read request whose synchronised occupancy (write pointer minus read pointer, modulo the store depth) is at most one quarter of the active ring causes a positive slip. The word read jumps back so data is repeated. `slip_pos_evt_o` pulses with that word, and `slip_pos_o` becomes set.
- R3: A read request whose synchronised occupancy is at least three quarters of the active ring causes a negative slip. The word read jumps forward so data is skipped. `slip_neg_evt_o` pulses with that word, and `slip_neg_o` becomes set.
- R4: The word returned on a slip is the one stored half the active ring behind the synchronised write pointer. Its age relative to the newest written word is therefore half the ring plus the synchroniser lag.
- R5: `mode_i` encodes the active ring: 2'b00 is 64 words, 2'b01 is 32 words, 2'b10 is 16 words and 2'b11 is bypass. Guard and repositioning distances scale with the selected ring.
- R6: `clr_i` clears both sticky flags on the next system clock edge. A slip in the same cycle as `clr_i` keeps its flag set.
- R7: After reset, and on the cycle after any change of `mode_i`, both flags are clear and `rd_valid_o` is low.
- R8: While `rd_en_i` is low, the read pointer sits half the active ring behind the synchronised write pointer. The first word read afterwards is that word.
- R9: In bypass, `rd_data_o` equals `wr_data_i`, `rd_valid_o` equals `wr_en_i`, `tsa_en_o` is low, and no slip event occurs. In every other mode `tsa_en_o` is high.
- R10: Outside bypass and mode changes, a read request is answered by `rd_valid_o` high on the following system clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Recovered line clock |
| wrst_ni | input | 1 | Line-domain reset, active low |
| wr_en_i | input | 1 | Store `wr_data_i` at the write pointer |
| wr_data_i | input | DW | Received line word |
| rclk_i | input | 1 | System backplane clock |
| rrst_ni | input | 1 | System-domain reset, active low |
| rd_en_i | input | 1 | Read request |
| mode_i | input | 2 | Ring size or bypass select |
| clr_i | input | 1 | Clear strobe for both sticky slip flags |
| rd_data_o | output | DW | Word read, or line word in bypass |
| rd_valid_o | output | 1 | `rd_data_o` carries a word |
| slip_pos_evt_o | output | 1 | Current word follows a positive slip |
| slip_neg_evt_o | output | 1 | Current word follows a negative slip |
| slip_pos_o | output | 1 | Sticky positive-slip flag |
| slip_neg_o | output | 1 | Sticky negative-slip flag |
| tsa_en_o | output | 1 | Enable for the downstream time-slot stage |

## Verification
The bench builds the block with its defaults: 8-bit words, a 64-word store (AW = 6) and a two-stage synchroniser. With these values all three ring lengths can be exercised, with guard distances of 16, 8 and 4 words. Running the line clock about 5 % faster or slower than the system clock brings repeated positive and negative slips in every ring within a few hundred cycles. The store is small enough that any stale or overwritten word shows up as a broken count sequence at the scoreboard. The two-stage synchroniser keeps the pointer lag to a few words, so each slip landing point can be checked against a tight window.

// File: rtl/slip_eb_pkg.sv
package slip_eb_pkg;

  typedef enum logic [1:0] {
    EB_TWO_FRAME = 2'b00,
    EB_ONE_FRAME = 2'b01,
    EB_SHORT     = 2'b10,
    EB_BYPASS    = 2'b11
  } eb_mode_e;

  // active ring length in words for a store of 2**aw words (R5)
  function automatic int unsigned ring_words(input logic [1:0] mode, input int unsigned aw);
    int unsigned full;
    full = 32'd1 << aw;
    case (mode)
      EB_ONE_FRAME: ring_words = full >> 1;
      EB_SHORT:     ring_words = full >> 2;
      default:      ring_words = full;
    endcase
  endfunction

endpackage

// File: rtl/slip_eb_sync.sv
module slip_eb_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/slip_eb_ram.sv
module slip_eb_ram #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) store[waddr_i] <= wdata_i;
  end

  assign rdata_o = store[raddr_i];
endmodule

// File: rtl/slip_eb_wr.sv
module slip_eb_wr #(
  parameter int AW = 6
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_en_i,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] wgray_o
);
  logic [AW-1:0] wptr_q, wptr_nxt;

  assign wptr_nxt = wptr_q + 1'b1;

  always_ff @(posedge wclk_i or negedge wrst_ni) begin
    if (!wrst_ni) begin
      wptr_q  <= '0;
      wgray_o <= '0;
    end else if (wr_en_i) begin
      wptr_q  <= wptr_nxt;
      wgray_o <= wptr_nxt ^ (wptr_nxt >> 1);
    end
  end

  assign wptr_o = wptr_q;
endmodule

// File: rtl/slip_eb_rd.sv
module slip_eb_rd
  import slip_eb_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rd_en_i,
  input  logic          clr_i,
  input  logic [1:0]    mode_i,
  input  logic [AW-1:0] wgray_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] raddr_o,
  output logic [DW-1:0] data_o,
  output logic          valid_o,
  output logic          pos_evt_o,
  output logic          neg_evt_o,
  output logic          pos_flag_o,
  output logic          neg_flag_o,
  output logic          pos_slip_o,
  output logic          neg_slip_o,
  output logic          reinit_o,
  output logic          bypass_o
);
  localparam int RW = AW + 1;

  logic [AW-1:0] wbin, rptr_q, occ, park, half_w;
  logic [AW:0]   ring_w, guard_w;
  logic [1:0]    mode_q;
  logic          pos_hit, neg_hit;

  always_comb begin
    for (int i = 0; i < AW; i++) wbin[i] = ^(wgray_i >> i);
  end

  assign ring_w  = RW'(ring_words(mode_i, AW));
  assign half_w  = ring_w[AW:1];
  assign guard_w = {2'b00, ring_w[AW:2]};

  assign occ     = wbin - rptr_q;
  assign park    = wbin - half_w;
  assign pos_hit = ({1'b0, occ} <= guard_w);
  assign neg_hit = ({1'b0, occ} >= (ring_w - guard_w));

  assign reinit_o   = (mode_i != mode_q);
  assign bypass_o   = (mode_i == EB_BYPASS);
  assign pos_slip_o = rd_en_i & ~bypass_o & ~reinit_o & pos_hit;
  assign neg_slip_o = rd_en_i & ~bypass_o & ~reinit_o & neg_hit;
  assign raddr_o    = (pos_slip_o | neg_slip_o) ? park : rptr_q;

  always_ff @(posedge rclk_i or negedge rrst_ni) begin
    if (!rrst_ni) begin
      mode_q     <= mode_i;
      rptr_q     <= park;
      data_o     <= '0;
      valid_o    <= 1'b0;
      pos_evt_o  <= 1'b0;
      neg_evt_o  <= 1'b0;
      pos_flag_o <= 1'b0;
      neg_flag_o <= 1'b0;
    end else begin
      mode_q    <= mode_i;
      pos_evt_o <= pos_slip_o;
      neg_evt_o <= neg_slip_o;
      if (reinit_o) begin
        pos_flag_o <= 1'b0;
        neg_flag_o <= 1'b0;
      end else begin
        pos_flag_o <= (pos_flag_o & ~clr_i) | pos_slip_o;
        neg_flag_o <= (neg_flag_o & ~clr_i) | neg_slip_o;
      end
      if (reinit_o || bypass_o || !rd_en_i) begin
        rptr_q  <= park;
        valid_o <= 1'b0;
      end else begin
        rptr_q  <= raddr_o + 1'b1;
        data_o  <= mem_rdata_i;
        valid_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/slip_elastic_buffer.sv
module slip_elastic_buffer
  import slip_eb_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wclk_i,
  input  logic          wrst_ni,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          rclk_i,
  input  logic          rrst_ni,
  input  logic          rd_en_i,
  input  logic [1:0]    mode_i,
  input  logic          clr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          rd_valid_o,
  output logic          slip_pos_evt_o,
  output logic          slip_neg_evt_o,
  output logic          slip_pos_o,
  output logic          slip_neg_o,
  output logic          tsa_en_o
);
  logic [AW-1:0] wptr_w, wgray_w, wgray_sync_w, raddr_w;
  logic [DW-1:0] mem_rdata_w, data_q_w;
  logic          valid_q_w;
  // named internal events for the checker
  logic          pos_slip_w, neg_slip_w, reinit_w, bypass_w;

  slip_eb_wr #(.AW(AW)) u_wr (
    .wclk_i (wclk_i),
    .wrst_ni(wrst_ni),
    .wr_en_i(wr_en_i),
    .wptr_o (wptr_w),
    .wgray_o(wgray_w)
  );

  slip_eb_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk_i (wclk_i),
    .we_i   (wr_en_i),
    .waddr_i(wptr_w),
    .wdata_i(wr_data_i),
    .raddr_i(raddr_w),
    .rdata_o(mem_rdata_w)
  );

  slip_eb_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (rclk_i),
    .rst_ni(rrst_ni),
    .d_i   (wgray_w),
    .q_o   (wgray_sync_w)
  );

  slip_eb_rd #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i     (rclk_i),
    .rrst_ni    (rrst_ni),
    .rd_en_i    (rd_en_i),
    .clr_i      (clr_i),
    .mode_i     (mode_i),
    .wgray_i    (wgray_sync_w),
    .mem_rdata_i(mem_rdata_w),
    .raddr_o    (raddr_w),
    .data_o     (data_q_w),
    .valid_o    (valid_q_w),
    .pos_evt_o  (slip_pos_evt_o),
    .neg_evt_o  (slip_neg_evt_o),
    .pos_flag_o (slip_pos_o),
    .neg_flag_o (slip_neg_o),
    .pos_slip_o (pos_slip_w),
    .neg_slip_o (neg_slip_w),
    .reinit_o   (reinit_w),
    .bypass_o   (bypass_w)
  );

  assign rd_data_o  = bypass_w ? wr_data_i : data_q_w;
  assign rd_valid_o = bypass_w ? wr_en_i : valid_q_w;
  assign tsa_en_o   = ~bypass_w;
endmodule

// File: rtl/slip_eb_chk.sv
module slip_eb_chk (
  input logic rclk_i,
  input logic rrst_ni,
  input logic rd_en_i,
  input logic clr_i,
  input logic bypass_w,
  input logic reinit_w,
  input logic pos_slip_w,
  input logic neg_slip_w,
  input logic slip_pos_evt_o,
  input logic slip_neg_evt_o,
  input logic slip_pos_o,
  input logic slip_neg_o,
  input logic rd_valid_o,
  input logic tsa_en_o
);
  // R2 / R3: a slip goes one way only
  p_evt_excl_r2: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !(slip_pos_evt_o && slip_neg_evt_o));

  // R2: a positive event is always accompanied by the sticky flag
  p_pos_sticky_r2: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    slip_pos_evt_o |-> slip_pos_o);

  // R3: same for the negative flag
  p_neg_sticky_r3: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    slip_neg_evt_o |-> slip_neg_o);

  // R6: a slip beats a simultaneous clear
  p_slip_beats_clr_r6: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (pos_slip_w && clr_i) |=> slip_pos_o);

  // R6: without clear or mode change a flag holds
  p_flag_hold_r6: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (slip_neg_o && !clr_i && !reinit_w) |=> slip_neg_o);

  // R7: a mode change clears both flags
  p_reinit_clear_r7: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    reinit_w |=> (!slip_pos_o && !slip_neg_o));

  // R9: bypass produces no slip and disables the slot stage
  p_bypass_quiet_r9: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (bypass_w && !pos_slip_w && !neg_slip_w) |=> (!slip_pos_evt_o && !slip_neg_evt_o));

  p_bypass_tsa_r9: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    bypass_w |-> !tsa_en_o);

  // R10: one-cycle read latency
  p_valid_lat_r10: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    (rd_en_i && !bypass_w && !reinit_w) |=> (rd_valid_o || bypass_w));

  // R2 / R3: slip decisions never overlap
  p_slip_excl_r3: assert property (@(posedge rclk_i) disable iff (!rrst_ni)
    !(pos_slip_w && neg_slip_w));
endmodule

bind slip_elastic_buffer slip_eb_chk u_chk (
  .rclk_i        (rclk_i),
  .rrst_ni       (rrst_ni),
  .rd_en_i       (rd_en_i),
  .clr_i         (clr_i),
  .bypass_w      (bypass_w),
  .reinit_w      (reinit_w),
  .pos_slip_w    (pos_slip_w),
  .neg_slip_w    (neg_slip_w),
  .slip_pos_evt_o(slip_pos_evt_o),
  .slip_neg_evt_o(slip_neg_evt_o),
  .slip_pos_o    (slip_pos_o),
  .slip_neg_o    (slip_neg_o),
  .rd_valid_o    (rd_valid_o),
  .tsa_en_o      (tsa_en_o)
);

// File: tb/sim_slip_elastic_buffer.sv
`timescale 1ns/1ps
module sim_slip_elastic_buffer;
  localparam int DW = 8;
  localparam int AW = 6;

  logic          wclk = 1'b0, rclk = 1'b0;
  logic          wrst_ni, rrst_ni, wr_en_i, rd_en_i, clr_i;
  logic [DW-1:0] wr_data_i;
  logic [1:0]    mode_i;
  logic [DW-1:0] rd_data_o;
  logic          rd_valid_o, slip_pos_evt_o, slip_neg_evt_o, slip_pos_o, slip_neg_o, tsa_en_o;

  real whalf = 10.0;
  int  total = 0, bad = 0;
  int  wcount = 0;
  int  exp_q[$];
  bit  wr_run = 0, man = 0, mon_on = 0, prev_v = 0, done = 0;
  int  last = 0, npos = 0, nneg = 0, nevt = 0, cur_half = 32;
  int  p0, n0, e0;

  slip_elastic_buffer #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) u0 (
    .wclk_i(wclk), .wrst_ni(wrst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rclk_i(rclk), .rrst_ni(rrst_ni), .rd_en_i(rd_en_i), .mode_i(mode_i), .clr_i(clr_i),
    .rd_data_o(rd_data_o), .rd_valid_o(rd_valid_o),
    .slip_pos_evt_o(slip_pos_evt_o), .slip_neg_evt_o(slip_neg_evt_o),
    .slip_pos_o(slip_pos_o), .slip_neg_o(slip_neg_o), .tsa_en_o(tsa_en_o)
  );

  initial forever #10 rclk = ~rclk;          // 50 MHz system clock
  initial forever #(whalf) wclk = ~wclk;     // line clock, rate varied by phase

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  // driver: presents a counting sequence and pushes each stored word as expected
  always @(negedge wclk) begin
    if (wr_run) begin
      wr_en_i   = 1'b1;
      wr_data_i = wcount[7:0];
    end else if (!man) begin
      wr_en_i = 1'b0;
    end
  end

  always @(posedge wclk) begin
    if (wr_en_i && !man) begin
      exp_q.push_back(wcount);
      wcount++;
    end
  end

  always @(negedge rclk) if (slip_pos_evt_o || slip_neg_evt_o) nevt++;

  // monitor: pops expected words, realigns at slips and after idle gaps
  always @(negedge rclk) begin
    int d, lag, step, e;
    if (mon_on && rd_valid_o) begin
      d = int'(rd_data_o);
      if (!prev_v || slip_pos_evt_o || slip_neg_evt_o) begin
        lag = (wcount - cur_half - d) & 255;
        if (slip_pos_evt_o || slip_neg_evt_o)
          chk(lag <= 8, "R4 slip lands half ring behind writer (R5 size)", lag, 8);
        else
          chk(lag <= 8, "R8 first word after idle is half ring behind", lag, 8);
        if (slip_pos_evt_o) begin
          step = ((last + 1) - d) & 255;
          chk(step >= 1 && step <= 128, "R2 positive slip repeats data", step, 1);
          npos++;
        end
        if (slip_neg_evt_o) begin
          step = (d - (last + 1)) & 255;
          chk(step >= 1 && step <= 128, "R3 negative slip skips data", step, 1);
          nneg++;
        end
        exp_q.delete();
        for (int v = wcount - cur_half - lag + 1; v < wcount; v++) exp_q.push_back(v);
      end else begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 scoreboard empty", d, -1);
        end else begin
          e = exp_q.pop_front();
          chk((e & 255) == d, "R1 in-order word", d, e & 255);
        end
      end
      last = d;
    end
    prev_v = mon_on && rd_valid_o;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    wrst_ni = 0; rrst_ni = 0; rd_en_i = 0; clr_i = 0; mode_i = 2'b00;
    wr_en_i = 0; wr_data_i = '0;
    wait_r(4);
    wrst_ni = 1; rrst_ni = 1;
    @(negedge rclk);
    // R7 reset state
    chk(rd_valid_o == 1'b0, "R7 reset valid low", rd_valid_o, 0);
    chk(!slip_pos_o && !slip_neg_o, "R7 reset flags clear", {slip_pos_o, slip_neg_o}, 0);
    chk(tsa_en_o == 1'b1, "R9 slot stage enabled outside bypass", tsa_en_o, 1);

    // equal rates, two-frame ring
    wr_run = 1;
    wait_r(60);
    rd_en_i = 1; mon_on = 1;
    @(negedge rclk);
    chk(rd_valid_o == 1'b1, "R10 valid one cycle after request", rd_valid_o, 1);
    p0 = npos; n0 = nneg;
    wait_r(400);
    chk(npos == p0 && nneg == n0, "R1 no slip at equal rates", npos + nneg - p0 - n0, 0);
    chk(!slip_pos_o && !slip_neg_o, "R1 flags stay clear", {slip_pos_o, slip_neg_o}, 0);
    rd_en_i = 0;
    @(negedge rclk);
    chk(rd_valid_o == 1'b0, "R10 valid drops with request", rd_valid_o, 0);

    // slow line clock: reader faster -> positive slips
    whalf = 10.5;
    wait_r(20);
    rd_en_i = 1; p0 = npos; n0 = nneg;
    wait_r(1500);
    chk(npos > p0, "R2 positive slips seen", npos - p0, 1);
    chk(nneg == n0, "R2 no negative slip", nneg - n0, 0);
    chk(slip_pos_o == 1'b1, "R2 positive flag sticky", slip_pos_o, 1);
    chk(slip_neg_o == 1'b0, "R2 negative flag clear", slip_neg_o, 0);

    // R6 clear strobe
    rd_en_i = 0;
    wait_r(5);
    clr_i = 1;
    @(negedge rclk);
    clr_i = 0;
    chk(!slip_pos_o && !slip_neg_o, "R6 clear strobe clears flags", {slip_pos_o, slip_neg_o}, 0);

    // fast line clock: reader slower -> negative slips
    whalf = 9.5;
    rd_en_i = 1; p0 = npos; n0 = nneg;
    wait_r(1500);
    chk(nneg > n0, "R3 negative slips seen", nneg - n0, 1);
    chk(npos == p0, "R3 no positive slip", npos - p0, 0);
    chk(slip_neg_o == 1'b1, "R3 negative flag sticky", slip_neg_o, 1);

    // R7 mode change to one-frame ring clears flags
    mode_i = 2'b01; cur_half = 16;
    @(negedge rclk);
    chk(!slip_pos_o && !slip_neg_o, "R7 mode change clears flags", {slip_pos_o, slip_neg_o}, 0);
    chk(rd_valid_o == 1'b0, "R7 mode change drops valid", rd_valid_o, 0);
    n0 = nneg;
    wait_r(1000);
    chk(nneg > n0, "R5 one-frame ring negative slips", nneg - n0, 1);
    whalf = 10.5; p0 = npos;
    wait_r(1000);
    chk(npos > p0, "R5 one-frame ring positive slips", npos - p0, 1);

    // R5 short ring
    mode_i = 2'b10; cur_half = 8;
    @(negedge rclk);
    p0 = npos;
    wait_r(800);
    chk(npos > p0, "R5 short ring positive slips", npos - p0, 1);
    whalf = 9.5; n0 = nneg;
    wait_r(800);
    chk(nneg > n0, "R5 short ring negative slips", nneg - n0, 1);

    // R9 bypass
    mon_on = 0;
    mode_i = 2'b11;
    @(negedge rclk);
    chk(tsa_en_o == 1'b0, "R9 slot stage disabled in bypass", tsa_en_o, 0);
    chk(!slip_pos_o && !slip_neg_o, "R9 flags clear entering bypass", {slip_pos_o, slip_neg_o}, 0);
    @(negedge rclk);
    e0 = nevt;
    wait_r(300);
    chk(nevt == e0, "R9 no slip events in bypass", nevt - e0, 0);
    chk(!slip_pos_o && !slip_neg_o, "R9 flags stay clear in bypass", {slip_pos_o, slip_neg_o}, 0);
    man = 1; wr_run = 0;
    wait_r(2);
    wr_data_i = 8'hA5; wr_en_i = 1'b1;
    #1;
    chk(rd_data_o == 8'hA5, "R9 bypass data passes through", rd_data_o, 8'hA5);
    chk(rd_valid_o == 1'b1, "R9 bypass valid follows write enable", rd_valid_o, 1);
    wr_data_i = 8'h3C; wr_en_i = 1'b0;
    #1;
    chk(rd_data_o == 8'h3C, "R9 bypass data follows input", rd_data_o, 8'h3C);
    chk(rd_valid_o == 1'b0, "R9 bypass valid low with write enable low", rd_valid_o, 0);

    done = 1;
    finish_run();
  end
endmodule